// File: doc/BRIEF.md
# Selectable Timer/Event Count Front End

This block decides, cycle by cycle, whether a 16-bit event counter advances. In timer mode the counter steps on every clock. In counter mode it steps on edges of an external capture pin: rising edges, falling edges or both. The pin is one of two, picked by a select field.

The selected pin is asynchronous, so each pin passes through a synchronizer chain before its edges are detected. An edge is found by comparing the latest synchronized sample with the one taken a cycle earlier. When the mode or select field changes, the comparison in that cycle is discarded, so switching pins cannot fake an edge. In counter mode a clear request is sent to the prescaler, so each qualifying edge advances the main counter directly. The block drives a one-cycle increment strobe and holds the counter that the strobe advances.

Top module: `tick_source_sel`

## Requirements
- R1: While `rst_n` is low, `event_count` is 0. The registered copies of the mode and select fields reset to 00, which is timer mode with pin 0 selected.
- R2: With `cnt_mode` = 00 (timer), `inc_strobe` is 1 every cycle and `event_count` advances by one on every rising clock edge. Capture pin activity has no effect.
- R3: With `cnt_mode` = 01, the counter advances by one for each rising edge of the selected pin. Falling edges give no increment.
- R4: With `cnt_mode` = 10, the counter advances by one for each falling edge of the selected pin. Rising edges give no increment.
- R5: With `cnt_mode` = 11, the counter advances by one for each rising edge and for each falling edge of the selected pin.
- R6: `pin_sel` = 00 selects `cap_pin[0]` and `pin_sel` = 01 selects `cap_pin[1]`. Edges on the pin that is not selected have no effect.
- R7: `pin_sel` = 10 and `pin_sel` = 11 are reserved. With either code in a counter mode, no increments occur whatever the pins do.
- R8: A pin change applied between clock edges raises `inc_strobe` after the second rising clock edge that follows it, which is the synchronizer delay. `event_count` shows the increment after the third edge, and the strobe lasts one cycle.
- R9: In a counter mode, no increment occurs in a cycle where `cnt_mode` or `pin_sel` differs from its value at the previous clock edge. This holds even when the newly selected pin's level differs from the previous sample.
- R10: `presc_clr` is 1 whenever `cnt_mode` is not 00, and 0 in timer mode.
- R11: `event_count` wraps from all ones to zero on its next increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_mode | input | 2 | 00 timer, 01 rising, 10 falling, 11 both edges |
| pin_sel | input | 2 | 00 pin 0, 01 pin 1, 10/11 reserved |
| cap_pin | input | 2 | Asynchronous capture pins |
| inc_strobe | output | 1 | Counter advances at the next clock edge |
| presc_clr | output | 1 | Hold prescaler cleared (counter mode) |
| event_count | output | CNT_W | Event counter value |

## Verification
The main stimulus is a sequence of vectors that walks every mode through rising and falling pin transitions on both the selected and the unselected pin. This shows whether the edge polarity is decoded correctly and whether the pin mux picks the right pin. Some vectors change only the configuration while the pin levels are left alone, and one switches to a pin at a different level. These show whether a configuration change is wrongly counted as an edge. Reserved select codes are driven with active pins to show that their output is fully suppressed. Directed tests then measure the strobe latency edge by edge and drive the counter through its wrap.

// File: rtl/tick_source_sel.sv
module tick_source_sel #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cnt_mode,
  input  logic [1:0]       pin_sel,
  input  logic [1:0]       cap_pin,
  output logic             inc_strobe,
  output logic             presc_clr,
  output logic [CNT_W-1:0] event_count
);
  localparam logic [1:0] MODE_TIMER = 2'b00;
  localparam logic [1:0] MODE_RISE  = 2'b01;
  localparam logic [1:0] MODE_FALL  = 2'b10;

  logic [1:0] synced;
  logic [1:0] mode_q, sel_q;
  logic       prev_q;
  logic       cur, rise, fall, sel_ok, cfg_chg, edge_hit;

  for (genvar p = 0; p < 2; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-2:0], cap_pin[p]};
    assign synced[p] = chain[SYNC_STAGES-1];
  end

  assign sel_ok  = ~pin_sel[1];
  assign cur     = sel_ok & synced[pin_sel[0]];
  assign cfg_chg = (cnt_mode != mode_q) | (pin_sel != sel_q);
  assign rise    = cur & ~prev_q;
  assign fall    = ~cur & prev_q;

  always_comb begin
    case (cnt_mode)
      MODE_RISE: edge_hit = rise;
      MODE_FALL: edge_hit = fall;
      default:   edge_hit = rise | fall;
    endcase
  end

  assign presc_clr  = (cnt_mode != MODE_TIMER);
  assign inc_strobe = presc_clr ? (edge_hit & sel_ok & ~cfg_chg) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_TIMER;
      sel_q       <= 2'b00;
      prev_q      <= 1'b0;
      event_count <= '0;
    end else begin
      mode_q <= cnt_mode;
      sel_q  <= pin_sel;
      prev_q <= cur;
      if (inc_strobe) event_count <= event_count + 1'b1;
    end
  end
endmodule

module tick_source_sel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cnt_mode,
  input logic [1:0]       pin_sel,
  input logic             inc_strobe,
  input logic [CNT_W-1:0] event_count
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  always @(posedge clk)
    if (!rst_n) assert_reset_zero_R1: assert (event_count == '0);

  assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(cnt_mode) == 2'b00 && $past(event_count) != '1)
      |-> event_count == $past(event_count) + 1'b1);

  assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode != 2'b00 && pin_sel[1]) |-> !inc_strobe);

  assert_cfg_change_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && cnt_mode != 2'b00 && (cnt_mode != $past(cnt_mode) || pin_sel != $past(pin_sel)))
      |-> !inc_strobe);

  assert_hold_without_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(inc_strobe)) |-> $stable(event_count));

  assert_wrap_to_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(inc_strobe) && $past(event_count) == '1) |-> event_count == '0);
endmodule

bind tick_source_sel tick_source_sel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode), .pin_sel(pin_sel),
  .inc_strobe(inc_strobe), .event_count(event_count)
);

// File: tb/tick_source_sel_bench.sv
module tick_source_sel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cnt_mode = 2'b00, pin_sel = 2'b00, cap_pin = 2'b00;
  logic inc_strobe, presc_clr;
  logic [15:0] event_count;
  int checks = 0, errors = 0;
  logic [15:0] base;

  always #2 clk = ~clk;

  tick_source_sel u_tick_source_sel (
    .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode), .pin_sel(pin_sel),
    .cap_pin(cap_pin), .inc_strobe(inc_strobe), .presc_clr(presc_clr),
    .event_count(event_count)
  );

  // {mode, sel, pin0, pin1, expected increments over 4 clock edges}
  localparam int NV = 25;
  localparam logic [8:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b0, 1'b0, 3'd4},
    {2'd0, 2'd0, 1'b1, 1'b1, 3'd4},
    {2'd1, 2'd0, 1'b1, 1'b1, 3'd0},
    {2'd1, 2'd0, 1'b0, 1'b1, 3'd0},
    {2'd1, 2'd0, 1'b1, 1'b1, 3'd1},
    {2'd1, 2'd0, 1'b1, 1'b0, 3'd0},
    {2'd1, 2'd0, 1'b1, 1'b1, 3'd0},
    {2'd1, 2'd1, 1'b1, 1'b1, 3'd0},
    {2'd1, 2'd1, 1'b1, 1'b0, 3'd0},
    {2'd1, 2'd1, 1'b1, 1'b1, 3'd1},
    {2'd1, 2'd1, 1'b0, 1'b1, 3'd0},
    {2'd1, 2'd0, 1'b0, 1'b1, 3'd0},
    {2'd1, 2'd1, 1'b0, 1'b1, 3'd0},
    {2'd2, 2'd1, 1'b0, 1'b1, 3'd0},
    {2'd2, 2'd1, 1'b0, 1'b0, 3'd1},
    {2'd2, 2'd1, 1'b0, 1'b1, 3'd0},
    {2'd3, 2'd1, 1'b0, 1'b1, 3'd0},
    {2'd3, 2'd1, 1'b0, 1'b0, 3'd1},
    {2'd3, 2'd1, 1'b0, 1'b1, 3'd1},
    {2'd3, 2'd2, 1'b0, 1'b1, 3'd0},
    {2'd3, 2'd2, 1'b1, 1'b0, 3'd0},
    {2'd3, 2'd3, 1'b0, 1'b1, 3'd0},
    {2'd3, 2'd0, 1'b0, 1'b1, 3'd0},
    {2'd3, 2'd0, 1'b1, 1'b1, 3'd1},
    {2'd0, 2'd0, 1'b1, 1'b1, 3'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    check(event_count == 16'd0, "R1 count in reset", event_count, 0);
    rst_n = 1'b1;
    tick(2);

    for (int i = 0; i < NV; i++) begin
      base = event_count;
      cnt_mode   = VEC[i][8:7];
      pin_sel    = VEC[i][6:5];
      cap_pin[0] = VEC[i][4];
      cap_pin[1] = VEC[i][3];
      #0;
      check(presc_clr == (VEC[i][8:7] != 2'b00), "R10 prescaler clear", presc_clr,
            int'(VEC[i][8:7] != 2'b00));
      tick(4);
      check(16'(event_count - base) == 16'(VEC[i][2:0]),
            $sformatf("R2/R3/R4/R5/R6/R7/R9 vector %0d", i),
            16'(event_count - base), VEC[i][2:0]);
    end

    // R8 latency
    cnt_mode = 2'd1; pin_sel = 2'd0; cap_pin = 2'b00;
    tick(5);
    base = event_count;
    cap_pin[0] = 1'b1;
    tick(1);
    check(inc_strobe == 1'b0, "R8 strobe after one edge", inc_strobe, 0);
    tick(1);
    check(inc_strobe == 1'b1, "R8 strobe after two edges", inc_strobe, 1);
    check(event_count == base, "R8 count before third edge", event_count, base);
    tick(1);
    check(event_count == 16'(base + 1), "R8 count after third edge", event_count, base + 1);
    check(inc_strobe == 1'b0, "R8 strobe one cycle", inc_strobe, 0);

    // R1 reset mid-run, then R11 wrap in timer mode
    cnt_mode = 2'd0; cap_pin = 2'b00;
    tick(3);
    rst_n = 1'b0;
    #1;
    check(event_count == 16'd0, "R1 async reset clears", event_count, 0);
    tick(2);
    rst_n = 1'b1;
    tick(65535);
    check(event_count == 16'hFFFF, "R11 reaches all ones", event_count, 16'hFFFF);
    check(inc_strobe == 1'b1, "R2 strobe in timer mode", inc_strobe, 1);
    tick(1);
    check(event_count == 16'd0, "R11 wraps to zero", event_count, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule